// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block is the digital sequencer of a single-wire automotive bus transceiver. It tracks battery power-up, a waiting state (two variants, chosen by the chip-select level when the regulator comes up), the operational state in which the transmitter may drive the bus, and a low-power state in which the regulator is switched off but the receiver keeps listening. Analog functions such as slew shaping, regulation and thermal sensing appear only as digital flags at its inputs.

The slew-rate choice is read from a shared pin once per battery power-up, while the pin's output driver is released. It then stays fixed through every sleep and wake until the battery flag drops. The transmitter is enabled only after a rising chip-select edge that arrives once the regulator has been stable for a programmable delay, which is derived from the clock frequency parameter. A thermal shutdown latch cuts the transmitter when over-temperature occurs while the bus is being driven dominant. The same latch drives the fault level onto the shared pin.

Top module: `lin_mode_ctrl`

## Requirements
- R1: With reset low or the battery flag low, `mode_o` reads 0 (power-off). `tx_en_o`, `rx_en_o`, `slope_fast_o` and `slope_pin_oe_o` are 0 and `rxd_o` is 1. The mode encodings are 0 off, 1 ready, 2 ready-1, 3 operational and 4 low-power.
- R2: In power-off, `slope_pin_oe_o` is 0. On the first clock edge with `reg_ok_i` high, `slope_fast_o` takes the inverse of `slope_pin_i` (pin low selects the fast slope, so the output is 1). In every other mode `slope_pin_oe_o` is 1.
- R3: On leaving power-off, the block enters ready (1) if the synchronised chip-select is high and ready-1 (2) if it is low.
- R4: From ready or ready-1, a chip-select rising edge moves the block to operational only once `reg_ok_i` has been high for DELAY_US microseconds of clock cycles. An earlier edge is ignored.
- R5: In operational mode, a low chip-select moves the block to low-power (4). There `reg_en_o` and `tx_en_o` are 0 and `rx_en_o` is 1.
- R6: A chip-select rising edge in low-power moves the block to ready (1). `slope_fast_o` is unchanged through sleep and wake.
- R7: In operational mode, `ovt_i` high together with `txd_i` low sets thermal shutdown on the next edge. This gives `tx_en_o` 0 and `fault_o` 1. `ovt_i` with `txd_i` high does not set it.
- R8: Thermal shutdown stays set until `ovt_i` is low at a clock edge. It then clears, and `tx_en_o` returns to 1.
- R9: `bus_dom_o` is 1 exactly when `tx_en_o` is 1 and `txd_i` is 0.
- R10: `rxd_o` equals `bus_i` when `rx_en_o` is 1, and is 1 otherwise.
- R11: A low battery flag returns the block to power-off asynchronously, without waiting for a clock edge, and clears `slope_fast_o`.
- R12: Chip-select passes through a two-flop synchroniser. A change made between edges is acted on at the third following rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bat_ok_i | input | 1 | Battery supply good |
| reg_ok_i | input | 1 | Regulator output stable |
| cs_i | input | 1 | Chip-select / wake, asynchronous |
| txd_i | input | 1 | Transmit data |
| ovt_i | input | 1 | Over-temperature flag |
| slope_pin_i | input | 1 | Level read from the shared slope/fault pin |
| bus_i | input | 1 | Bus level from the comparator |
| mode_o | output | 3 | Current mode |
| tx_en_o | output | 1 | Transmitter enable |
| reg_en_o | output | 1 | Regulator enable |
| rx_en_o | output | 1 | Receiver enable |
| slope_fast_o | output | 1 | Latched slope choice, 1 = fast |
| slope_pin_oe_o | output | 1 | Output enable of the shared pin |
| fault_o | output | 1 | Fault level for the shared pin |
| bus_dom_o | output | 1 | Drive the bus dominant |
| rxd_o | output | 1 | Receive data |

## Verification
The bench sweeps every pairing of slope-pin level and power-up chip-select level. It checks the chosen ready variant and the latched slope, which exposes an inverted slope code or a swapped ready choice. It raises chip-select right after the regulator becomes stable, where a design that skipped the delay would enter operation too early. It then walks through sleep and wake to catch a slope bit that gets re-sampled or cleared. The thermal sequence drives over-temperature with transmit data high and then low. A latch that ignored the data condition, or that released before the flag cleared, would be reported there. The battery flag is dropped between clock edges to expose a synchronous-only return to power-off.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;
  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_RDY  = 3'd1,
    ST_RDY1 = 3'd2,
    ST_OPER = 3'd3,
    ST_LOWP = 3'd4
  } lin_mode_e;
endpackage

// File: rtl/lin_cs_sync.sv
module lin_cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  output logic lvl_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], cs_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/lin_delay_timer.sv
module lin_delay_timer #(
  parameter int CYC = 12000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int W = $clog2(CYC + 1);
  localparam logic [W-1:0] LIMIT = W'(CYC);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LIMIT);
endmodule

// File: rtl/lin_slope_latch.sv
module lin_slope_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_i,
  input  logic pin_i,
  output logic fast_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    fast_o <= 1'b0;
    else if (cap_i) fast_o <= ~pin_i;  // low pin level selects fast slope
  end
endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
  import lin_mode_pkg::*;
#(
  parameter int CLK_HZ   = 20_000_000,
  parameter int DELAY_US = 600
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bat_ok_i,
  input  logic       reg_ok_i,
  input  logic       cs_i,
  input  logic       txd_i,
  input  logic       ovt_i,
  input  logic       slope_pin_i,
  input  logic       bus_i,
  output logic [2:0] mode_o,
  output logic       tx_en_o,
  output logic       reg_en_o,
  output logic       rx_en_o,
  output logic       slope_fast_o,
  output logic       slope_pin_oe_o,
  output logic       fault_o,
  output logic       bus_dom_o,
  output logic       rxd_o
);
  localparam int DELAY_CYC = (CLK_HZ / 1_000_000) * DELAY_US;

  // battery loss acts as an asynchronous reset of the whole block
  logic rst_int_n;
  assign rst_int_n = rst_ni & bat_ok_i;

  lin_mode_e state_q, state_d;
  logic      cs_lvl, cs_rise, dly_done, tsd_q, cap;

  lin_cs_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_int_n),
    .cs_i  (cs_i),
    .lvl_o (cs_lvl),
    .rise_o(cs_rise)
  );

  lin_delay_timer #(.CYC(DELAY_CYC)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_int_n),
    .run_i (reg_ok_i),
    .done_o(dly_done)
  );

  assign cap = (state_q == ST_OFF) && reg_ok_i;

  lin_slope_latch u_slope (
    .clk_i (clk_i),
    .rst_ni(rst_int_n),
    .cap_i (cap),
    .pin_i (slope_pin_i),
    .fast_o(slope_fast_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:          if (reg_ok_i) state_d = cs_lvl ? ST_RDY : ST_RDY1;
      ST_RDY, ST_RDY1: if (cs_rise && dly_done) state_d = ST_OPER;
      ST_OPER:         if (!cs_lvl) state_d = ST_LOWP;
      ST_LOWP:         if (cs_rise) state_d = ST_RDY;
      default:         state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= ST_OFF;
    else            state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n)                                    tsd_q <= 1'b0;
    else if (!ovt_i)                                   tsd_q <= 1'b0;
    else if (state_q == ST_OPER && !txd_i)             tsd_q <= 1'b1;
  end

  assign mode_o         = state_q;
  assign tx_en_o        = (state_q == ST_OPER) && !tsd_q;
  assign reg_en_o       = (state_q != ST_LOWP);
  assign rx_en_o        = (state_q != ST_OFF);
  assign slope_pin_oe_o = (state_q != ST_OFF);
  assign fault_o        = tsd_q;
  assign bus_dom_o      = tx_en_o & ~txd_i;
  assign rxd_o          = rx_en_o ? bus_i : 1'b1;
endmodule

// File: rtl/lin_mode_chk.sv
module lin_mode_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bat_ok_i,
  input logic       reg_ok_i,
  input logic       txd_i,
  input logic [2:0] mode_o,
  input logic       tx_en_o,
  input logic       reg_en_o,
  input logic       rx_en_o,
  input logic       slope_fast_o,
  input logic       slope_pin_oe_o,
  input logic       fault_o,
  input logic       bus_dom_o
);
  // R6
  slope_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !bat_ok_i)
    (mode_o != 3'd0 && $past(mode_o) != 3'd0) |-> $stable(slope_fast_o));
  // R2
  pin_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !bat_ok_i)
    (mode_o == 3'd0) |-> !slope_pin_oe_o);
  // R4
  oper_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !bat_ok_i)
    (mode_o == 3'd3 && $past(mode_o) != 3'd3) |-> $past(reg_ok_i));
  // R5
  lowp_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !bat_ok_i)
    (mode_o == 3'd4) |-> (!reg_en_o && !tx_en_o && rx_en_o));
  // R7
  tx_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !bat_ok_i)
    tx_en_o |-> (mode_o == 3'd3 && !fault_o));
  // R9
  bus_dom_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !bat_ok_i)
    bus_dom_o |-> (tx_en_o && !txd_i));
endmodule

bind lin_mode_ctrl lin_mode_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bat_ok_i      (bat_ok_i),
  .reg_ok_i      (reg_ok_i),
  .txd_i         (txd_i),
  .mode_o        (mode_o),
  .tx_en_o       (tx_en_o),
  .reg_en_o      (reg_en_o),
  .rx_en_o       (rx_en_o),
  .slope_fast_o  (slope_fast_o),
  .slope_pin_oe_o(slope_pin_oe_o),
  .fault_o       (fault_o),
  .bus_dom_o     (bus_dom_o)
);

// File: tb/sim_lin_mode_ctrl.sv
`timescale 1ns/1ps
module sim_lin_mode_ctrl;
  localparam int DLY = 20;  // cycles: 1 MHz nominal x 20 us

  logic clk = 1'b0, rst_n = 1'b0;
  logic bat_ok = 1'b0, reg_ok = 1'b0, cs = 1'b0, txd = 1'b1, ovt = 1'b0;
  logic slope_pin = 1'b1, bus = 1'b1;
  logic [2:0] mode;
  logic tx_en, reg_en, rx_en, slope_fast, pin_oe, fault, bus_dom, rxd;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lin_mode_ctrl #(.CLK_HZ(1_000_000), .DELAY_US(DLY)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bat_ok_i(bat_ok), .reg_ok_i(reg_ok),
    .cs_i(cs), .txd_i(txd), .ovt_i(ovt), .slope_pin_i(slope_pin), .bus_i(bus),
    .mode_o(mode), .tx_en_o(tx_en), .reg_en_o(reg_en), .rx_en_o(rx_en),
    .slope_fast_o(slope_fast), .slope_pin_oe_o(pin_oe), .fault_o(fault),
    .bus_dom_o(bus_dom), .rxd_o(rxd)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cs(input logic v);
    @(negedge clk) cs = v;
    repeat (3) @(posedge clk);  // R12: two sync flops, then the state flop
    @(negedge clk);
  endtask

  task automatic power_up(input logic pin, input logic cs0);
    @(negedge clk) bat_ok = 1'b0; reg_ok = 1'b0;
    repeat (2) @(negedge clk);
    cs = cs0; slope_pin = pin; bus = 1'b0; bat_ok = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 mode off", mode, 0);
    chk("R2 pin oe off", pin_oe, 0);
    chk("R10 rxd idle", rxd, 1);
    reg_ok = 1'b1;
    @(negedge clk);
    chk("R3 ready choice", mode, cs0 ? 1 : 2);
    chk("R2 slope code", slope_fast, pin ? 0 : 1);
    chk("R2 pin oe on", pin_oe, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset mode", mode, 0);
    chk("R1 reset tx", tx_en, 0);
    chk("R1 reset slope", slope_fast, 0);
    rst_n = 1'b1;
    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c < 2; c++) begin
        power_up(p[0], c[0]);
        if (c == 0) begin
          set_cs(1'b1);  // early edge, well before the delay expires
          chk("R4 early edge ignored", mode, 2);
          set_cs(1'b0);
        end else begin
          set_cs(1'b0);
          chk("R4 ready holds", mode, 1);
        end
        repeat (DLY + 5) @(negedge clk);
        set_cs(1'b1);
        chk("R4 enter oper", mode, 3);
        chk("R4 tx on", tx_en, 1);
        // bus drive and receive
        for (int t = 0; t < 2; t++) begin
          txd = t[0]; bus = ~t[0]; #1;
          chk("R9 bus drive", bus_dom, t == 0 ? 1 : 0);
          chk("R10 rxd follows", rxd, t == 0 ? 1 : 0);
        end
        // thermal
        @(negedge clk) txd = 1'b1; ovt = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7 no trip with txd high", tx_en, 1);
        txd = 1'b0;
        @(negedge clk);
        chk("R7 trip tx", tx_en, 0);
        chk("R7 fault", fault, 1);
        chk("R7 bus released", bus_dom, 0);
        txd = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 held while hot", tx_en, 0);
        ovt = 1'b0;
        @(negedge clk);
        chk("R8 recover", tx_en, 1);
        chk("R8 fault clear", fault, 0);
        // sleep and wake
        set_cs(1'b0);
        chk("R5 lowpower", mode, 4);
        chk("R5 reg off", reg_en, 0);
        chk("R5 rx on", rx_en, 1);
        reg_ok = 1'b0; slope_pin = ~p[0];
        repeat (3) @(negedge clk);
        set_cs(1'b1);
        chk("R6 wake to ready", mode, 1);
        chk("R6 slope kept", slope_fast, p == 0 ? 1 : 0);
        reg_ok = 1'b1;
        repeat (DLY + 5) @(negedge clk);
        set_cs(1'b0);
        set_cs(1'b1);
        chk("R6 reenter oper", mode, 3);
        chk("R6 slope still kept", slope_fast, p == 0 ? 1 : 0);
        // asynchronous battery loss
        @(negedge clk) bat_ok = 1'b0; #1;
        chk("R11 async off", mode, 0);
        chk("R11 slope cleared", slope_fast, 0);
        chk("R11 tx off", tx_en, 0);
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual 0 expected 1");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule